// File: doc/BRIEF.md
# Contiguous Slot Range Allocator

This block reserves a run of consecutive command slots for a deferred (sleep or wake) request. The slot pool is a group of `NUM_SETS` command sets with `CMDS_PER_SET` slots in each, held as one flat occupancy bitmap. A request gives a run length; the block looks for the first free run of that length, never lets a run straddle two sets, marks the run as taken, and reports which set it landed in and at which slot of that set it starts. When no set can hold the run, an out-of-space error is returned and nothing changes.

The search walks one set per clock, starting at set 0, so a request is answered after a number of cycles that grows with the index of the set that fits. `busy` is high while the walk is in progress and `done` pulses for one cycle with the result. The returned set index is the local index plus `SET_BASE`, the position of this group among all sets of the controller. An `invalidate` pulse, taken while idle, empties the bitmap. It also raises `wipe_stb` for one cycle so that the command-enable masks of the group's sets can be cleared, but only when the bitmap held something. The slot count per set is a parameter that must fit a 5-bit count field (at most 31).

Top module: `slot_run_alloc`

## Requirements
- R1: After reset `busy`, `done` and `wipe_stb` are low and every slot is free, so a first request of length 1 returns set `SET_BASE`, slot 0.
- R2: A request with length 0 or length above `CMDS_PER_SET` gives `done` with `err_len`=1 and `err_full`=0 in the cycle after acceptance. The bitmap stays unchanged.
- R3: On success the result is the lowest set k holding L free consecutive slots, at the lowest such start p in that set. The outputs are `set_idx` = `SET_BASE`+k and `cmd_idx` = p.
- R4: A free run that crosses from the last slots of one set into the first slots of the next is never returned. The search moves on to the next set boundary.
- R5: When no set holds a free run of length L, `done` comes with `err_full`=1 and `err_len`=0, and the bitmap is unchanged.
- R6: A successful request marks its L slots as taken, and later requests skip them until an invalidate.
- R7: After a valid request is accepted, `done` rises k+1 cycles later when the run lands in local set k. It rises `NUM_SETS` cycles later when the request fails for lack of space.
- R8: `busy` is high from the cycle after acceptance until `done`. `req_valid` and `invalidate` have no effect while `busy` is high.
- R9: `invalidate` while idle frees every slot. `wipe_stb` pulses for exactly one cycle after it, and only when at least one slot was taken.
- R10: When `invalidate` and `req_valid` are high together while idle, the invalidate is carried out and the request is dropped: no `busy`, no `done`.
- R11: `done` and `busy` are never high together, and `err_len` and `err_full` are never both set on a `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_len | input | LEN_W | Run length L |
| invalidate | input | 1 | Free all slots, taken when idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| err_len | output | 1 | Length was 0 or too large |
| err_full | output | 1 | No set has room |
| set_idx | output | SET_W | Set index including `SET_BASE` |
| cmd_idx | output | POS_W | First slot of the run within the set |
| wipe_stb | output | 1 | Clear command-enable masks of the group |

## Verification
The hardest case to reach is a fragmented pool in which the first free flat run crosses a set boundary while a later set still has room. From the ports this can only be built by an earlier allocation that leaves a short tail in one set while the next set is still untouched. The bench builds it directly by taking three slots of set 0 and then asking for two. It then runs a long pseudo-random mix of lengths, including illegal ones, with occasional invalidates. A bitmap model in the bench predicts every set, slot, error and latency. Stray requests and invalidates are also injected mid-search to show that they are ignored.

// File: rtl/slot_run_pkg.sv
package slot_run_pkg;

    // Upper bound on slots per set: the count lives in a 5-bit field.
    localparam int MAX_CMDS = 31;

    typedef enum logic {
        ST_IDLE,
        ST_SCAN
    } scan_state_e;

    typedef struct packed {
        logic len_bad;
        logic full;
    } fault_t;

    // Mask with the low 'len' bits set.
    function automatic logic [31:0] run_mask(input int unsigned len);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < len) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/slot_run_scan.sv
// First-fit search inside a single set: lowest start whose run of 'len'
// slots is free and ends inside the set.
module slot_run_scan
    import slot_run_pkg::*;
#(
    parameter int CMDS  = 4,
    parameter int LEN_W = 3,
    parameter int POS_W = 2
) (
    input  logic [CMDS-1:0]  bits,
    input  logic [LEN_W-1:0] len,
    output logic             found,
    output logic [POS_W-1:0] pos
);
    logic [31:0]     wide;
    logic [31:0]     mask;
    logic [CMDS-1:0] fit;

    assign wide = 32'(bits);
    assign mask = run_mask(32'(len));

    for (genvar p = 0; p < CMDS; p++) begin : g_pos
        assign fit[p] = ((p + int'(len)) <= CMDS) && (((wide >> p) & mask) == 32'd0);
    end

    always_comb begin
        found = |fit;
        pos   = '0;
        for (int p = CMDS - 1; p >= 0; p--) begin
            if (fit[p]) pos = POS_W'(p);
        end
    end
endmodule

// File: rtl/slot_run_map.sv
// Occupancy bitmap, one row per set.
module slot_run_map
    import slot_run_pkg::*;
#(
    parameter int SETS  = 3,
    parameter int CMDS  = 4,
    parameter int LEN_W = 3,
    parameter int POS_W = 2,
    parameter int SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 mark,
    input  logic [SEL_W-1:0]     sel,
    input  logic [POS_W-1:0]     pos,
    input  logic [LEN_W-1:0]     len,
    output logic [SETS*CMDS-1:0] map
);
    logic [CMDS-1:0] run;
    logic [CMDS-1:0] row [SETS];

    assign run = CMDS'(run_mask(32'(len)) << pos);

    for (genvar k = 0; k < SETS; k++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                row[k] <= '0;
            end else if (mark && (sel == SEL_W'(k))) begin
                row[k] <= row[k] | run;
            end
        end
        assign map[k*CMDS +: CMDS] = row[k];
    end
endmodule

// File: rtl/slot_run_alloc.sv
module slot_run_alloc
    import slot_run_pkg::*;
#(
    parameter int NUM_SETS     = 3,
    parameter int CMDS_PER_SET = 4,
    parameter int SET_BASE     = 2,
    parameter int LEN_W        = $clog2(CMDS_PER_SET + 1),
    parameter int POS_W        = (CMDS_PER_SET > 1) ? $clog2(CMDS_PER_SET) : 1,
    parameter int SET_W        = ((SET_BASE + NUM_SETS) > 1) ? $clog2(SET_BASE + NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    input  logic             invalidate,
    output logic             busy,
    output logic             done,
    output logic             err_len,
    output logic             err_full,
    output logic [SET_W-1:0] set_idx,
    output logic [POS_W-1:0] cmd_idx,
    output logic             wipe_stb
);
    localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
    localparam int MAP_W = NUM_SETS * CMDS_PER_SET;

    scan_state_e       state_q;
    logic [SEL_W-1:0]  scan_q;
    logic [LEN_W-1:0]  len_q;
    logic [MAP_W-1:0]  map;
    logic [CMDS_PER_SET-1:0] cur_bits;
    logic              hit;
    logic [POS_W-1:0]  hit_pos;
    logic              take_inval;
    logic              take_req;
    logic              len_ok;
    fault_t            fault_q;

    assign busy       = (state_q == ST_SCAN);
    assign take_inval = (state_q == ST_IDLE) && invalidate;
    assign take_req   = (state_q == ST_IDLE) && !invalidate && req_valid;
    assign len_ok     = (req_len != '0) && (int'(req_len) <= CMDS_PER_SET);
    assign cur_bits   = map[int'(scan_q)*CMDS_PER_SET +: CMDS_PER_SET];
    assign err_len    = fault_q.len_bad;
    assign err_full   = fault_q.full;

    slot_run_scan #(
        .CMDS (CMDS_PER_SET),
        .LEN_W(LEN_W),
        .POS_W(POS_W)
    ) u_scan (
        .bits (cur_bits),
        .len  (len_q),
        .found(hit),
        .pos  (hit_pos)
    );

    slot_run_map #(
        .SETS (NUM_SETS),
        .CMDS (CMDS_PER_SET),
        .LEN_W(LEN_W),
        .POS_W(POS_W),
        .SEL_W(SEL_W)
    ) u_map (
        .clk  (clk),
        .rst  (rst),
        .clear(take_inval),
        .mark (busy && hit),
        .sel  (scan_q),
        .pos  (hit_pos),
        .len  (len_q),
        .map  (map)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            scan_q   <= '0;
            len_q    <= '0;
            done     <= 1'b0;
            fault_q  <= '0;
            set_idx  <= '0;
            cmd_idx  <= '0;
            wipe_stb <= 1'b0;
        end else begin
            done     <= 1'b0;
            wipe_stb <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take_inval) begin
                        wipe_stb <= |map;
                    end else if (take_req) begin
                        if (!len_ok) begin
                            done    <= 1'b1;
                            fault_q <= '{len_bad: 1'b1, full: 1'b0};
                        end else begin
                            len_q   <= req_len;
                            scan_q  <= '0;
                            state_q <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (hit) begin
                        done    <= 1'b1;
                        fault_q <= '0;
                        set_idx <= SET_W'(SET_BASE) + SET_W'(scan_q);
                        cmd_idx <= hit_pos;
                        state_q <= ST_IDLE;
                    end else if (int'(scan_q) == NUM_SETS - 1) begin
                        done    <= 1'b1;
                        fault_q <= '{len_bad: 1'b0, full: 1'b1};
                        state_q <= ST_IDLE;
                    end else begin
                        scan_q <= scan_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/slot_run_alloc_chk.sv
module slot_run_alloc_chk #(
    parameter int NUM_SETS     = 3,
    parameter int CMDS_PER_SET = 4,
    parameter int SET_BASE     = 2,
    parameter int LEN_W        = 3,
    parameter int POS_W        = 2,
    parameter int SET_W        = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             invalidate,
    input logic             busy,
    input logic             done,
    input logic             err_len,
    input logic             err_full,
    input logic [SET_W-1:0] set_idx,
    input logic [POS_W-1:0] cmd_idx,
    input logic             wipe_stb
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    a_r2_len_reject: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && !invalidate && (req_len == '0 || int'(req_len) > CMDS_PER_SET))
        |=> (done && err_len && !err_full));

    a_r8_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && !invalidate && req_len != '0 && int'(req_len) <= CMDS_PER_SET)
        |=> busy);

    a_r10_inval_wins: assert property (@(posedge clk) disable iff (rst)
        (!busy && invalidate) |=> (!busy && !done));

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    a_r11_err_excl: assert property (@(posedge clk) disable iff (rst)
        done |-> !(err_len && err_full));

    a_r3_result_range: assert property (@(posedge clk) disable iff (rst)
        (done && !err_len && !err_full) |->
        (int'(set_idx) >= SET_BASE && int'(set_idx) < SET_BASE + NUM_SETS
         && int'(cmd_idx) < CMDS_PER_SET));

    a_r9_wipe_cause: assert property (@(posedge clk) disable iff (rst)
        wipe_stb |-> ($past(invalidate) && !$past(busy)));

    a_r7_scan_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < NUM_SETS));
endmodule

bind slot_run_alloc slot_run_alloc_chk #(
    .NUM_SETS    (NUM_SETS),
    .CMDS_PER_SET(CMDS_PER_SET),
    .SET_BASE    (SET_BASE),
    .LEN_W       (LEN_W),
    .POS_W       (POS_W),
    .SET_W       (SET_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_len   (req_len),
    .invalidate(invalidate),
    .busy      (busy),
    .done      (done),
    .err_len   (err_len),
    .err_full  (err_full),
    .set_idx   (set_idx),
    .cmd_idx   (cmd_idx),
    .wipe_stb  (wipe_stb)
);

// File: tb/tb_slot_run_alloc.sv
module tb_slot_run_alloc;
    localparam int S     = 3;
    localparam int C     = 4;
    localparam int BASE  = 2;
    localparam int LEN_W = 3;
    localparam int POS_W = 2;
    localparam int SET_W = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic             invalidate = 1'b0;
    logic             busy, done, err_len, err_full, wipe_stb;
    logic [SET_W-1:0] set_idx;
    logic [POS_W-1:0] cmd_idx;

    slot_run_alloc #(.NUM_SETS(S), .CMDS_PER_SET(C), .SET_BASE(BASE)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
        .invalidate(invalidate), .busy(busy), .done(done), .err_len(err_len),
        .err_full(err_full), .set_idx(set_idx), .cmd_idx(cmd_idx), .wipe_stb(wipe_stb)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit mdl [S*C];
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit cond, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic bit mdl_any();
        for (int i = 0; i < S*C; i++) if (mdl[i]) return 1'b1;
        return 1'b0;
    endfunction

    // First set with a free run inside it, lowest start.
    task automatic mdl_find(input int len, output bit ok, output int k, output int p);
        ok = 0; k = 0; p = 0;
        for (int s = 0; s < S && !ok; s++) begin
            for (int q = 0; q + len <= C && !ok; q++) begin
                bit freer = 1;
                for (int l = 0; l < len; l++) if (mdl[s*C+q+l]) freer = 0;
                if (freer) begin ok = 1; k = s; p = q; end
            end
        end
    endtask

    task automatic do_alloc(input int len, input bit stray, input string rq);
        bit bad, ok;
        int k, p, n, exp_n;
        bad = (len == 0) || (len > C);
        mdl_find(len, ok, k, p);
        exp_n = bad ? 1 : (ok ? k + 2 : S + 1);
        @(negedge clk); req_valid = 1'b1; req_len = LEN_W'(len);
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0; n = 1;
        if (!done && stray) begin req_valid = 1'b1; req_len = 1; invalidate = 1'b1; end
        while (!done && n < 20) begin
            chk(busy, "R8", "busy during search", busy, 1);
            @(posedge clk);
            @(negedge clk); req_valid = 1'b0; invalidate = 1'b0; n++;
        end
        chk(n == exp_n, "R7", "latency", n, exp_n);
        if (bad) begin
            chk(err_len && !err_full, "R2", "len error flags", {err_len, err_full}, 2);
        end else if (!ok) begin
            chk(err_full && !err_len, "R5", "full error flags", {err_len, err_full}, 1);
        end else begin
            chk(!err_len && !err_full, "R3", "no error", {err_len, err_full}, 0);
            chk(int'(set_idx) == BASE + k, rq, "set index", set_idx, BASE + k);
            chk(int'(cmd_idx) == p, rq, "slot index", cmd_idx, p);
            for (int l = 0; l < len; l++) mdl[k*C+p+l] = 1'b1;
        end
        @(negedge clk);
        chk(!done && !busy, "R11", "done single pulse", {done, busy}, 0);
    endtask

    task automatic do_inval(input bit with_req);
        bit exp_w;
        exp_w = mdl_any();
        @(negedge clk); invalidate = 1'b1;
        if (with_req) begin req_valid = 1'b1; req_len = 1; end
        @(posedge clk);
        @(negedge clk); invalidate = 1'b0; req_valid = 1'b0;
        chk(wipe_stb == exp_w, "R9", "wipe strobe", wipe_stb, exp_w);
        chk(!busy && !done, "R10", "request dropped", {busy, done}, 0);
        for (int i = 0; i < S*C; i++) mdl[i] = 1'b0;
        @(negedge clk);
        chk(!wipe_stb && !done, "R9", "wipe single pulse", wipe_stb, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        for (int i = 0; i < S*C; i++) mdl[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !wipe_stb, "R1", "reset outputs", {busy, done, wipe_stb}, 0);
        rst = 1'b0;
        do_alloc(1, 0, "R1");
        do_inval(0);
        // R4: set 0 tail slot free, set 1 empty, length 2 must go to set 1
        do_alloc(3, 0, "R3");
        do_alloc(2, 0, "R4");
        chk(int'(set_idx) == BASE + 1 && cmd_idx == 0, "R4", "no straddle", set_idx, BASE + 1);
        do_alloc(0, 0, "R2");
        do_alloc(C + 1, 0, "R2");
        do_alloc(1, 1, "R6");
        do_alloc(C, 1, "R6");
        do_alloc(C, 0, "R5");
        do_inval(1);
        do_inval(0);
        for (int it = 0; it < 400; it++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) do_inval(lfsr[3]);
            else do_alloc(int'(lfsr[15:8]) % (C + 2), lfsr[4] & lfsr[5], "R3");
        end
        summary();
    end
endmodule